// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block drives the word address for each beat of a four-beat memory burst. A start address is captured when either of two active-low address strobes is seen at a rising clock edge: one strobe comes from the processor side and one from the memory-controller side. From then on, the two low address bits are produced by an internal two-bit beat counter. That counter steps only in cycles where the active-low advance input is asserted. When advance is not asserted the counter holds, which gives a wait state.

The ordering of the low bits is chosen by a mode input, sampled together with the start address. Linear order adds the beat number to the start bits modulo four. Interleaved order XORs the beat number into the start bits. The upper address bits stay fixed for the whole burst. A strobe that arrives part-way through a burst restarts the sequence at once. A flag marks the fourth beat.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, at the next rising edge `addr_out` becomes all zeros and `last_beat` becomes 0.
- R2: When `ads_proc_n` is 0 at a rising edge, after that edge `addr_out` equals the `addr_in` sampled at that edge, and the beat number is 0.
- R3: When `ads_ctrl_n` is 0 at a rising edge, the load is the same as in R2. Both strobes low together also give a single load.
- R4: With both strobes high and `adv_n` 0 at a rising edge, the beat number goes up by one (modulo 4) and the low two bits of `addr_out` change.
- R5: With both strobes and `adv_n` high at a rising edge, `addr_out` and `last_beat` keep their values.
- R6: With `mode_ilv` = 0 at load, the low two bits at beat k are (start low bits + k) mod 4.
- R7: With `mode_ilv` = 1 at load, the low two bits at beat k are (start low bits XOR k).
- R8: Bits above bit 1 of `addr_out` never change between loads. After beat 3, one more advance returns to beat 0 with no carry into the upper bits.
- R9: `last_beat` is 1 exactly when the beat number is 3.
- R10: A strobe in the same cycle as an active `adv_n` loads and does not advance. A strobe during a burst restarts it at beat 0.
- R11: `mode_ilv` counts only at load. Changing it during a burst has no effect on `addr_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ads_proc_n | input | 1 | Processor-side address strobe, active low |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_ilv | input | 1 | Order select at load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address of the current beat |
| last_beat | output | 1 | High on the fourth beat |

## Verification
A load and an advance can fall in the same cycle. This happens whenever a strobe and an active `adv_n` are driven on the same clock edge. The bench does this both at the start of a burst and half-way through one, and expects `addr_out` to equal the newly captured address at beat 0, with `last_beat` low. A mode change is also driven in the middle of a burst, alongside advances. It is judged by the sequence following the order that was captured at load.

// File: rtl/burst_pkg.sv
// Package: shared types for the burst address generator.
// Assumes: the beat counter width is fixed at two bits (four-beat bursts).
package burst_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_base_reg.sv
// Module: burst_base_reg
// Holds the start address and the beat order captured on a load.
// Assumes: load is already qualified (either strobe); no enable otherwise.
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_d,
    input  burst_order_e      order_d,
    output logic [ADDR_W-1:0] base_q,
    output burst_order_e      order_q
);
    // Capture start address and order on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_LINEAR;
        end else if (load) begin
            base_q  <= addr_d;
            order_q <= order_d;
        end
    end
endmodule

// File: rtl/burst_beat_counter.sv
// Module: burst_beat_counter
// Wrapping beat counter: cleared by load, stepped by advance.
// Assumes: load has priority over advance; the counter wraps freely.
module burst_beat_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_last
);
    // Clear on reset or load, increment modulo 2**CNT_W on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final beat of the burst.
    always_comb at_last = &cnt_q;
endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps the start low bits and the beat number to the low address bits.
// Assumes: purely combinational; the order value is held stable per burst.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_lo,
    input  logic [CNT_W-1:0] beat,
    input  burst_order_e     order,
    output logic [CNT_W-1:0] addr_lo
);
    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] ilv_lo;

    // Linear order: modular add of the beat number.
    always_comb lin_lo = start_lo + beat;

    // Interleaved order: per-bit XOR of the beat number.
    for (genvar i = 0; i < CNT_W; i++) begin : g_ilv
        assign ilv_lo[i] = start_lo[i] ^ beat[i];
    end

    // Pick the order captured at load.
    always_comb addr_lo = (order == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Generates per-beat addresses for four-beat bursts in linear or
// interleaved order; loads on either active-low strobe.
// Assumes: all control inputs are synchronous to clk; ADDR_W > 2.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              last_beat
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic              advance;
    logic [ADDR_W-1:0] base_q;
    burst_order_e      order_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] lo_bits;

    // Either strobe loads; advance only applies when there is no load.
    always_comb begin
        load    = !ads_proc_n || !ads_ctrl_n;
        advance = !adv_n && !load;
    end

    burst_base_reg #(.ADDR_W(ADDR_W)) base_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_d  (addr_in),
        .order_d (burst_order_e'(mode_ilv)),
        .base_q  (base_q),
        .order_q (order_q)
    );

    burst_beat_counter #(.CNT_W(BEAT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .cnt_q   (beat_q),
        .at_last (last_beat)
    );

    burst_order_map #(.CNT_W(BEAT_W)) map_i (
        .start_lo (base_q[BEAT_W-1:0]),
        .beat     (beat_q),
        .order    (order_q),
        .addr_lo  (lo_bits)
    );

    // Upper bits come straight from the captured base.
    always_comb addr_out = {base_q[ADDR_W-1 -: HI_W], lo_bits};
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Port-level temporal checks for burst_addr_gen, bound to the top.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ads_proc_n,
    input logic              ads_ctrl_n,
    input logic              adv_n,
    input logic              mode_ilv,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              last_beat
);
    localparam int LO_W = 2;

    logic strobe;
    always_comb strobe = !ads_proc_n || !ads_ctrl_n;

    // R2 R3
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> addr_out == $past(addr_in));

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !adv_n) |=> !last_beat);

    // R4
    advance_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !adv_n) |=> addr_out[LO_W-1:0] != $past(addr_out[LO_W-1:0]));

    // R5
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && adv_n) |=> ($stable(addr_out) && $stable(last_beat)));

    // R8
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(addr_out[ADDR_W-1:LO_W]));

    // R9
    last_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !strobe && !adv_n) |=> !last_beat);

    logic unused_mode;
    always_comb unused_mode = mode_ilv;
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .mode_ilv   (mode_ilv),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .last_beat  (last_beat)
);

// File: tb/burst_addr_gen_tb_top.sv
// Scoreboard bench: the driver task applies a cycle and queues the
// expected outputs; the monitor compares them just after the clock edge.
module burst_addr_gen_tb_top;
    localparam int AW = 17;

    typedef struct {
        logic [AW-1:0] addr;
        logic          last;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ads_proc_n = 1'b1;
    logic          ads_ctrl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          mode_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          last_beat;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // Reference state, built from the requirements.
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic          m_ilv = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
        .adv_n(adv_n), .mode_ilv(mode_ilv), .addr_in(addr_in),
        .addr_out(addr_out), .last_beat(last_beat)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: one cycle of stimulus, with the expected result queued.
    task automatic drive(input logic ps, input logic cs, input logic adv,
                         input logic mode, input logic [AW-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        ads_proc_n = ps; ads_ctrl_n = cs; adv_n = adv; mode_ilv = mode; addr_in = a;
        if (!ps || !cs) begin
            m_base = a; m_beat = 2'd0; m_ilv = mode;
        end else if (!adv) begin
            m_beat = m_beat + 2'd1;
        end
        e.addr = exp_addr(); e.last = (m_beat == 2'd3); e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (addr_out !== e.addr || last_beat !== e.last) begin
                n_bad++;
                $display("FAIL %s: addr_out=%h last=%b expected addr_out=%h last=%b",
                         e.tag, addr_out, last_beat, e.addr, e.last);
            end
        end
    end

    // Watchdog.
    initial begin
        #(5 * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        // R1: reset state
        if (addr_out !== '0 || last_beat !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: addr_out=%h last=%b expected 0 0", addr_out, last_beat);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R6: processor strobe, linear from low bits 01.
        drive(0, 1, 1, 0, 17'h0A5D1, "R2");
        for (int k = 0; k < 4; k++) drive(1, 1, 0, 0, 17'h1FFFF, "R6");
        drive(1, 1, 0, 0, 17'h00000, "R8");
        // R5: wait states hold.
        drive(1, 1, 1, 1, 17'h12345, "R5");
        drive(1, 1, 1, 0, 17'h00000, "R5");

        // R3 R7: controller strobe, interleaved from 10, with waits.
        drive(1, 0, 1, 1, 17'h13572, "R3");
        drive(1, 1, 0, 1, 17'h0, "R7");
        drive(1, 1, 1, 1, 17'h0, "R5");
        drive(1, 1, 0, 1, 17'h0, "R7");
        drive(1, 1, 0, 1, 17'h0, "R9");
        drive(1, 1, 0, 1, 17'h0, "R8");

        // R8 R6: low bits 11 linear, no carry into upper bits.
        drive(0, 1, 0, 0, 17'h00007, "R10");
        for (int k = 0; k < 5; k++) drive(1, 1, 0, 1, 17'h0, "R8");

        // R11: mode flips during an interleaved burst from 01.
        drive(0, 0, 1, 1, 17'h1ABC1, "R3");
        drive(1, 1, 0, 0, 17'h0, "R11");
        drive(1, 1, 0, 0, 17'h0, "R11");
        drive(1, 1, 0, 1, 17'h0, "R11");

        // R10: reload mid-burst with advance active.
        drive(1, 0, 0, 0, 17'h04446, "R10");
        drive(1, 1, 0, 1, 17'h0, "R6");
        drive(0, 1, 0, 1, 17'h0F0F3, "R10");
        drive(1, 1, 0, 1, 17'h0, "R7");
        drive(1, 1, 0, 1, 17'h0, "R7");
        drive(1, 1, 0, 1, 17'h0, "R9");
        drive(1, 1, 1, 1, 17'h0, "R9");

        drive(1, 1, 1, 0, 17'h0, "R5");
        repeat (3) @(posedge clk);
        #2;
        summary();
    end
endmodule